// File: doc/BRIEF.md
# Triangular 15-Tap Decimating Line Filter

This block smooths and thins a one-dimensional pixel stream. Pixels arrive four at a time on a valid/ready input. They collect in a 16-pixel buffer. Whenever five pixels are waiting, they move as a group into a 15-pixel register window.

Each move forms a weighted sum of the window. The weights rise from 1 to 8 and fall back to 1, and they total 64. The sum is rounded and shifted right by six bits, so each output is a low-pass, alias-suppressed average. One output is produced for every five input pixels, which decimates the stream by 5.

A flag on the last input beat marks the end of a line. The block then drains its buffer and pads the final partial group with zeros. It clears the window so the next line starts fresh.

The controller has three named states:
- `ST_LOAD`: the window holds fewer than 15 pixels of the current line.
- `ST_RUN`: the window is full, so each group move produces an output.
- `ST_FLUSH`: a line end has been accepted and input is held off while the buffer drains.

The transitions are:
- load-to-run: the group move that completes the window.
- any-to-flush: a beat with the line-end flag is accepted.
- flush-to-load: the buffer is empty, and the window fill count is cleared.

Top module: `tri15_decim`

## Requirements
- R1: Each output equals min(2^PW-1, (sum over i=0..14 of w_i*p_i + 32) >> 6), where w_i = i+1 for i<8 and 15-i otherwise. p_0 is the oldest pixel in the window.
- R2: Within a line, successive outputs come from windows whose first pixel positions differ by exactly 5.
- R3: The first output of a line uses line pixels 0..14. A line that yields fewer than 15 padded pixels gives no output.
- R4: Lane 0 (in_pix bits PW-1:0) is the earliest pixel of a beat. Lane k (bits k*PW+PW-1 : k*PW) follows lane k-1.
- R5: in_ready is high only when at least 4 of the 16 buffer slots are free. It stays high throughout a line, because the buffer drains five pixels per move against four arriving per beat.
- R6: Accepting a beat with in_last=1 drops in_ready on the next cycle until the line is drained. The line tail is zero-padded to a multiple of 5 pixels, so a line of N pixels gives ceil(N/5)-2 outputs (never negative).
- R7: An all-maximum window produces 2^PW-1, the largest value the output can hold.
- R8: After reset, out_valid is low and in_ready is high.
- R9: Each line starts with an empty window. No pixel of one line contributes to an output of the next.
- R10: in_pix and in_last are ignored in cycles where in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input beat is offered |
| in_ready | output | 1 | The block takes the beat at this edge |
| in_pix | input | LANES*PW | Four pixels, lane 0 earliest |
| in_last | input | 1 | The beat ends the current line |
| out_valid | output | 1 | out_pix holds a filtered sample |
| out_pix | output | PW | Filtered, decimated pixel |

## Verification
The assertions assume the source respects in_ready: no beat is counted unless in_ready is high. The source also never sends data for a new line before the flush completes, which the block enforces through in_ready.

The bench drives each beat only while in_ready is high. It inserts idle cycles that carry garbage data and a raised in_last, to show they are ignored. Line lengths are swept from shorter than one window to several windows, in ramp, constant, impulse and pseudo-random patterns. Every expected output is computed arithmetically from the padded line.

// File: rtl/tri15_pkg.sv
`timescale 1ns/1ps
package tri15_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } tri15_state_e;

    // Triangular weight for tap i of an odd-length kernel: rises to the centre, then falls.
    function automatic int tap_weight(input int i, input int taps);
        return (i < taps / 2) ? i + 1 : taps - i;
    endfunction

endpackage

// File: rtl/tri15_fifo.sv
`timescale 1ns/1ps
module tri15_fifo #(
    parameter int PW    = 8,
    parameter int LANES = 4,
    parameter int GROUP = 5,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [LANES*PW-1:0]   din,
    input  logic [CW-1:0]         pop_n,
    output logic [CW-1:0]         cnt,
    output logic [GROUP*PW-1:0]   head
);

    logic [PW-1:0] mem     [DEPTH];
    logic [PW-1:0] mem_nxt [DEPTH];
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        int rem;
        rem = int'(cnt) - int'(pop_n);
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = i + int'(pop_n);
            mem_nxt[i] = (src < int'(cnt) && src < DEPTH) ? mem[src] : '0;
            if (push && i >= rem && i < rem + LANES)
                mem_nxt[i] = din[(i - rem)*PW +: PW];
        end
        cnt_nxt = cnt - pop_n + (push ? CW'(LANES) : CW'(0));
    end

    always_comb begin
        for (int g = 0; g < GROUP; g++)
            head[g*PW +: PW] = (g < int'(cnt)) ? mem[g] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            cnt <= cnt_nxt;
            for (int i = 0; i < DEPTH; i++) mem[i] <= mem_nxt[i];
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(cnt) - int'(pop_n) + LANES <= DEPTH));

    // R5
    pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n <= cnt);

endmodule

// File: rtl/tri15_window.sv
`timescale 1ns/1ps
module tri15_window
    import tri15_pkg::*;
#(
    parameter int PW    = 8,
    parameter int GROUP = 5,
    parameter int SHIFT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic [GROUP*PW-1:0]  group_in,
    input  logic                 load,
    output logic                 out_valid,
    output logic [PW-1:0]        out_pix
);

    localparam int TAPS = 3 * GROUP;
    localparam int SW   = PW + SHIFT + 2;
    localparam logic [SW-1:0] PMAX = SW'((1 << PW) - 1);

    logic [PW-1:0] win [TAPS];
    logic [SW-1:0] acc, rounded;
    logic [PW-1:0] sat;

    always_comb begin
        acc = '0;
        for (int i = 0; i < TAPS; i++)
            acc = acc + SW'(tap_weight(i, TAPS)) * SW'(win[i]);
        rounded = (acc + SW'(1 << (SHIFT - 1))) >> SHIFT;
        sat     = (rounded > PMAX) ? PMAX[PW-1:0] : rounded[PW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) win[i] <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            if (shift) begin
                for (int i = 0; i < TAPS - GROUP; i++) win[i] <= win[i + GROUP];
                for (int g = 0; g < GROUP; g++)
                    win[TAPS - GROUP + g] <= group_in[g*PW +: PW];
            end
            out_valid <= load;
            if (load) out_pix <= sat;
        end
    end

endmodule

// File: rtl/tri15_decim.sv
`timescale 1ns/1ps
module tri15_decim
    import tri15_pkg::*;
#(
    parameter int PW    = 8,
    parameter int LANES = 4,
    parameter int GROUP = 5,
    parameter int DEPTH = 16,
    parameter int SHIFT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [LANES*PW-1:0]  in_pix,
    input  logic                 in_last,
    output logic                 out_valid,
    output logic [PW-1:0]        out_pix
);

    localparam int CW = $clog2(DEPTH + 1);

    tri15_state_e state_q, state_d;
    logic [1:0]          fill_q;
    logic [CW-1:0]       cnt, pop_n;
    logic [GROUP*PW-1:0] head;
    logic                push, adv, emit, win_new_q;

    // Output process: decisions taken from the current state.
    always_comb begin
        adv      = (cnt >= CW'(GROUP)) || (state_q == ST_FLUSH && cnt != '0);
        pop_n    = (cnt >= CW'(GROUP)) ? CW'(GROUP) : (adv ? cnt : '0);
        emit     = adv && (fill_q >= 2'd2);
        in_ready = (state_q != ST_FLUSH) && (cnt <= CW'(DEPTH - LANES));
        push     = in_valid && in_ready;
    end

    // Next-state process.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (push && in_last) state_d = ST_FLUSH;
                      else if (emit)       state_d = ST_RUN;
            ST_RUN:   if (push && in_last) state_d = ST_FLUSH;
            ST_FLUSH: if (cnt == '0)       state_d = ST_LOAD;
            default:  state_d = ST_LOAD;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_LOAD;
            fill_q    <= '0;
            win_new_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            win_new_q <= emit;
            if (state_q == ST_FLUSH && cnt == '0) fill_q <= '0;
            else if (adv && fill_q != 2'd3)       fill_q <= fill_q + 2'd1;
        end
    end

    tri15_fifo #(.PW(PW), .LANES(LANES), .GROUP(GROUP), .DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(in_pix),
        .pop_n(pop_n), .cnt(cnt), .head(head)
    );

    tri15_window #(.PW(PW), .GROUP(GROUP), .SHIFT(SHIFT)) u_win (
        .clk(clk), .rst_n(rst_n), .shift(adv), .group_in(head),
        .load(win_new_q), .out_valid(out_valid), .out_pix(out_pix)
    );

    // R6
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R2
    out_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(adv, 2));

    // R9
    flush_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && cnt == '0) |=> (state_q == ST_LOAD && fill_q == 2'd0));

endmodule

// File: tb/sim_tri15_decim.sv
`timescale 1ns/1ps
module sim_tri15_decim;
    localparam int PW = 8;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready, out_valid;
    logic [LANES*PW-1:0] in_pix = '0;
    logic [PW-1:0] out_pix;

    int checks = 0, errors = 0;
    int exp_q[$];
    int got_q[$];
    bit done = 0;
    int lcg = 12345;

    always #2.5 clk = ~clk;

    tri15_decim #(.PW(PW), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_last(in_last), .out_valid(out_valid), .out_pix(out_pix)
    );

    always @(negedge clk) if (rst_n && out_valid) got_q.push_back(int'(out_pix));

    function automatic int next_rand();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >> 8) & 255;
    endfunction

    task automatic send_beat(input logic [LANES*PW-1:0] d, input bit last, input bit want_ready);
        @(negedge clk);
        in_valid = 1'b1; in_pix = d; in_last = last;
        if (want_ready) begin
            checks++;
            if (!in_ready) begin
                errors++;
                $display("FAIL R5 in_ready mid-line actual=%0b expected=1", in_ready);
            end
        end
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b1; in_pix = {LANES{8'hA5}};
        if (last) begin
            checks++;
            if (in_ready !== 1'b0) begin
                errors++;
                $display("FAIL R6 in_ready after line end actual=%0b expected=0", in_ready);
            end
        end
    endtask

    // pat: 0 ramp, 1 all max, 2 impulse at position arg, 3 pseudo-random
    task automatic run_line(input int beats, input int pat, input int arg, input int gap);
        int n = beats * LANES;
        int px[];
        int g, m;
        px = new[n];
        for (int i = 0; i < n; i++) begin
            case (pat)
                0: px[i] = (i * 7 + arg) & 255;
                1: px[i] = 255;
                2: px[i] = (i == arg) ? 255 : 0;
                default: px[i] = next_rand();
            endcase
        end
        // expected outputs (R1, R2, R3, R6 padding)
        g = (n + 4) / 5;
        m = g * 5;
        for (int k = 0; 5 * k + 15 <= m; k++) begin
            int s = 0;
            for (int i = 0; i < 15; i++) begin
                int p = (5 * k + i < n) ? px[5 * k + i] : 0;
                int w = (i < 7) ? i + 1 : 15 - i;
                s += w * p;
            end
            s = (s + 32) >> 6;
            exp_q.push_back(s > 255 ? 255 : s);
        end
        for (int b = 0; b < beats; b++) begin
            logic [LANES*PW-1:0] d;
            for (int l = 0; l < LANES; l++) d[l*PW +: PW] = px[b * LANES + l][PW-1:0];   // R4
            send_beat(d, b == beats - 1, b != 0 && gap == 0);
            for (int z = 0; z < gap; z++) @(negedge clk);   // R10 idle cycles with garbage
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R8 reset actual valid=%0b ready=%0b expected valid=0 ready=1", out_valid, in_ready);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_line(1, 0, 3, 0);    // R3 short line: no output
        run_line(3, 0, 1, 0);    // R3 12 px -> 15 padded -> one output
        run_line(4, 2, 0, 1);    // R1 impulse at tap 0
        run_line(5, 2, 7, 0);    // R1 impulse at centre
        run_line(5, 1, 0, 2);    // R7 all max
        run_line(8, 3, 0, 0);    // R2 random
        for (int len = 2; len <= 11; len++) run_line(len, 3, 0, len % 3);   // R6 R9 sweep
        for (int pos = 0; pos < 20; pos++) run_line(5, 2, pos, 0);        // R1 R4 impulse sweep
        run_line(10, 0, 9, 0);

        repeat (40) @(negedge clk);
        // R6
        checks++;
        if (got_q.size() != exp_q.size()) begin
            errors++;
            $display("FAIL R6 output count actual=%0d expected=%0d", got_q.size(), exp_q.size());
        end
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            // R1 R2 R3 R7 R9 R10
            checks++;
            if (got_q[i] != exp_q[i]) begin
                errors++;
                $display("FAIL R1 output %0d actual=%0d expected=%0d", i, got_q[i], exp_q[i]);
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule